// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a management-bus master that reaches registers inside Clause 45 PHYs over a two-wire MDC/MDIO link. A host programs it through four 32-bit registers selected by a 2-bit offset. Every access has two phases, and each phase is started by a register write. Writing the address register sends an address frame that carries the 16-bit register number. Writing the data register then sends a write frame, or setting the read bit in the control register sends a read frame. The PHY port number and the device number held in the control register apply to every frame that follows until they are changed.

MDC is derived from the system clock. Each MDC half-period lasts the programmed divider value in system clocks. The bidirectional MDIO wire is modelled as three signals: an output value, an output enable and a sampled input. The master changes its output only when MDC falls and samples the input when MDC rises. During a read it releases the wire for the turnaround and for the data field. If the PHY fails to pull the second turnaround bit low, the master flags a read error and returns all ones.

Top module: `mdio_c45_master`

Register offsets: 0 status, 1 control, 2 address, 3 data.

## Requirements
- R1: After reset the status register reads 0x0000_6400, meaning a divider of 100, no busy flag and no error. The data register reads 0, MDC is low and the output enable is low.
- R2: While a frame is in progress, each MDC half-period lasts max(divider, 1) system clocks. The divider sits in status bits [15:8]. MDC stays low and the output enable stays low while no frame is in progress.
- R3: Each frame is 64 bits long and is sent MSB first in this order: 32 ones, start bits 00, a 2-bit opcode (00 address, 01 write, 11 read), the port address from control[4:0], the device address from control[12:8], 2 turnaround bits and 16 payload bits.
- R4: Writing offset 2 stores bits [15:0] and sends an address frame that carries them. Writing offset 3 stores bits [15:0] and sends a write frame that carries them. Both address and write frames drive the turnaround as 10.
- R5: Writing control with bit 15 set sends a read frame. The output enable is low from the first turnaround bit to the end of the frame. The 16 bits sampled on the rising MDC edges of the data field appear in data register bits [15:0]. Control bit 15 always reads back as 0.
- R6: A read error is set when the second turnaround bit of a read is sampled high. It shows as status bit 1, and the data register then holds 0xFFFF. The error is cleared when a write frame or a read frame is launched. An address frame leaves it unchanged.
- R7: Status bit 0 (bus busy) is high from the cycle after a launching write until the frame ends. Data register bit 31 (data busy) is high over the same span, but only for write and read frames.
- R8: Any register write that arrives while bus busy is high is ignored, and no register changes.
- R9: During a frame, the MDIO output changes only in a cycle where MDC has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the offset on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | Sampled MDIO wire |

## Verification
Any wrong internal state eventually shows up on the pins or on the registers. A divider or phase counter that slips moves the next MDC edge, and a shift register or bit index that goes wrong alters the MDIO bit in the same MDC period. Either fault therefore appears within one bit time of the error. A turnaround or sampling fault during a read is only visible when the frame finishes, as a wrong data value or error flag. A stuck busy flag shows as a later launch that is silently dropped, and that is caught on the first cycle the expected frame should have started.

// File: rtl/mdio_c45_pkg.sv
// Shared types and frame layout for the Clause 45 management master.
// Assumes 16-bit register numbers and data and a fixed 64-bit frame.
package mdio_c45_pkg;

    localparam int REG_W      = 32;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;   // index of first turnaround bit
    localparam int DATA_FIRST = 48;   // index of first payload bit
    localparam int DIV_LSB    = 8;    // divider field position in status

    localparam logic [1:0] OFS_STATUS = 2'd0;
    localparam logic [1:0] OFS_CTRL   = 2'd1;
    localparam logic [1:0] OFS_ADDR   = 2'd2;
    localparam logic [1:0] OFS_DATA   = 2'd3;

    localparam int CTRL_READ_BIT = 15;
    localparam int DBUSY_BIT     = 31;

    // opcode values are used directly as the frame encoding
    typedef enum logic [1:0] {
        OP_ADDRESS = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b11
    } mdio_op_e;

    // assemble a full frame, MSB first
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input mdio_op_e    op,
        input logic [4:0]  port_ad,
        input logic [4:0]  dev_ad,
        input logic [15:0] body
    );
        logic [1:0]  ta;
        logic [15:0] pay;
        ta  = (op == OP_READ) ? 2'b11 : 2'b10;
        pay = (op == OP_READ) ? 16'hFFFF : body;
        return {{PRE_BITS{1'b1}}, 2'b00, op, port_ad, dev_ad, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_c45_mdc_gen.sv
// MDC generator: while run is high, toggles mdc every max(div,1) clocks,
// starting low. Gives one-cycle ticks in the cycle before each edge.
// Assumes div is held stable while run is high.
module mdio_c45_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             wrap;

    // zero divider behaves as one
    always_comb lim = (div == '0) ? ONE : div;

    // end of a half-period
    always_comb wrap = run && (cnt == (lim - ONE));

    // edge ticks aligned to the toggle
    always_comb begin
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    // half-period counter and clock output
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/mdio_c45_frame_engine.sv
// Frame engine: loads a 64-bit frame on start, shifts one bit per MDC
// falling tick, releases the line for the read turnaround and data, and
// samples the turnaround and data on rising ticks.
// Assumes start is only raised while idle.
module mdio_c45_frame_engine
    import mdio_c45_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  port_ad,
    input  logic [4:0]  dev_ad,
    input  logic [15:0] body,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_in,
    output logic        active,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rx_data,
    output logic        rx_err
);

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_FIRST + 1);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    mdio_op_e              op_q;
    logic                  ta_seen_high;
    logic                  is_rd;

    always_comb is_rd = (op_q == OP_READ);

    // last falling tick of the frame
    always_comb done = active && fall_tick && (idx == LAST_IDX);

    // line drive: idle holds one, read releases from turnaround onward
    always_comb begin
        mdio_out = active ? shreg[FRAME_BITS-1] : 1'b1;
        mdio_oe  = active && !(is_rd && (idx >= TA_IDX));
    end

    always_comb rx_err = ta_seen_high;

    // frame sequencing, shifting and receive capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            shreg        <= '1;
            idx          <= '0;
            op_q         <= OP_ADDRESS;
            rx_data      <= '0;
            ta_seen_high <= 1'b0;
        end else if (start && !active) begin
            active <= 1'b1;
            shreg  <= make_frame(op, port_ad, dev_ad, body);
            idx    <= '0;
            op_q   <= op;
        end else if (active) begin
            if (rise_tick && is_rd) begin
                if (idx == TA2_IDX)
                    ta_seen_high <= mdio_in;
                if (idx >= DAT_IDX)
                    rx_data <= {rx_data[14:0], mdio_in};
            end
            if (fall_tick) begin
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                end else begin
                    idx   <= idx + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

endmodule

// File: rtl/mdio_c45_regfile.sv
// Register file: holds divider, port/device numbers, register number and
// data; launches frames on register writes and absorbs read results.
// Assumes bus_busy covers the launch cycle as well as the frame.
module mdio_c45_regfile
    import mdio_c45_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             bus_busy,
    input  logic             eng_done,
    input  logic [15:0]      rx_data,
    input  logic             rx_err,
    output logic [DIV_W-1:0] div,
    output logic [4:0]       port_ad,
    output logic [4:0]       dev_ad,
    output logic             start,
    output mdio_op_e         op,
    output logic [15:0]      body,
    output logic             data_busy,
    output logic             rd_err,
    output logic [15:0]      data_q
);

    logic [15:0] regnum_q;
    logic        accept;

    always_comb accept = reg_wr && !bus_busy;

    // payload for the frame being launched
    always_comb body = (op == OP_ADDRESS) ? regnum_q : data_q;

    // register updates, frame launch and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div       <= DIV_RST;
            port_ad   <= '0;
            dev_ad    <= '0;
            regnum_q  <= '0;
            data_q    <= '0;
            rd_err    <= 1'b0;
            data_busy <= 1'b0;
            start     <= 1'b0;
            op        <= OP_ADDRESS;
        end else begin
            start <= 1'b0;
            if (eng_done) begin
                data_busy <= 1'b0;
                if (op == OP_READ) begin
                    rd_err <= rx_err;
                    data_q <= rx_err ? 16'hFFFF : rx_data;
                end
            end
            if (accept) begin
                case (reg_addr)
                    OFS_STATUS: div <= reg_wdata[DIV_LSB +: DIV_W];
                    OFS_CTRL: begin
                        port_ad <= reg_wdata[4:0];
                        dev_ad  <= reg_wdata[12:8];
                        if (reg_wdata[CTRL_READ_BIT]) begin
                            start     <= 1'b1;
                            op        <= OP_READ;
                            data_busy <= 1'b1;
                            rd_err    <= 1'b0;
                        end
                    end
                    OFS_ADDR: begin
                        regnum_q <= reg_wdata[15:0];
                        start    <= 1'b1;
                        op       <= OP_ADDRESS;
                    end
                    default: begin
                        data_q    <= reg_wdata[15:0];
                        start     <= 1'b1;
                        op        <= OP_WRITE;
                        data_busy <= 1'b1;
                        rd_err    <= 1'b0;
                    end
                endcase
            end
        end
    end

    // read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: begin
                reg_rdata[0]                = bus_busy;
                reg_rdata[1]                = rd_err;
                reg_rdata[DIV_LSB +: DIV_W] = div;
            end
            OFS_CTRL: begin
                reg_rdata[4:0]  = port_ad;
                reg_rdata[12:8] = dev_ad;
            end
            OFS_ADDR: reg_rdata[15:0] = regnum_q;
            default: begin
                reg_rdata[15:0]      = data_q;
                reg_rdata[DBUSY_BIT] = data_busy;
            end
        endcase
    end

endmodule

// File: rtl/mdio_c45_master.sv
// Top: Clause 45 management master. Ties register file, MDC generator
// and frame engine together. Assumes DIV_W + 8 <= 16 so the divider
// field fits the low half of status.
module mdio_c45_master
    import mdio_c45_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(100)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic             bus_busy;
    logic             active;
    logic             start;
    logic             eng_done;
    logic             rise_tick;
    logic             fall_tick;
    logic [DIV_W-1:0] div;
    logic [4:0]       port_ad;
    logic [4:0]       dev_ad;
    mdio_op_e         op;
    logic [15:0]      body;
    logic [15:0]      rx_data;
    logic             rx_err;
    logic             data_busy;
    logic             rd_err;
    logic [15:0]      data_q;

    // busy spans the launch cycle and the frame
    always_comb bus_busy = start || active;

    mdio_c45_regfile #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_busy  (bus_busy),
        .eng_done  (eng_done),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .div       (div),
        .port_ad   (port_ad),
        .dev_ad    (dev_ad),
        .start     (start),
        .op        (op),
        .body      (body),
        .data_busy (data_busy),
        .rd_err    (rd_err),
        .data_q    (data_q)
    );

    mdio_c45_mdc_gen #(
        .DIV_W (DIV_W)
    ) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_c45_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .port_ad   (port_ad),
        .dev_ad    (dev_ad),
        .body      (body),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .active    (active),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (eng_done),
        .rx_data   (rx_data),
        .rx_err    (rx_err)
    );

endmodule

// File: rtl/mdio_c45_sva.sv
// Checker for the management master, bound to the top module.
// Watches clock shape, line stability, busy nesting and error data.
module mdio_c45_sva #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc,
    input logic             mdio_out,
    input logic             mdio_oe,
    input logic             bus_busy,
    input logic             data_busy,
    input logic             rd_err,
    input logic [15:0]      data_q,
    input logic [DIV_W-1:0] div
);

    logic [DIV_W:0] run_len;
    logic           mdc_prev;
    logic [DIV_W:0] lim_ext;

    always_comb lim_ext = (div == '0) ? (DIV_W+1)'(1) : {1'b0, div};

    // length of the current constant stretch of mdc
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len  <= '0;
            mdc_prev <= 1'b0;
        end else begin
            mdc_prev <= mdc;
            if (mdc == mdc_prev)
                run_len <= run_len + 1'b1;
            else
                run_len <= (DIV_W+1)'(1);
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> (!mdc && !mdio_oe)); // R2

    AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (run_len == lim_ext)); // R2

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && $past(bus_busy) && !$fell(mdc)) |-> $stable(mdio_out)); // R9

    AST_DBUSY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        data_busy |-> bus_busy); // R7

    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (data_q == 16'hFFFF)); // R6

endmodule

bind mdio_c45_master mdio_c45_sva #(.DIV_W(DIV_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .bus_busy  (bus_busy),
    .data_busy (data_busy),
    .rd_err    (rd_err),
    .data_q    (data_q),
    .div       (div)
);

// File: tb/mdio_c45_master_bench.sv
// Bench: behavioural per-cycle model of the master plus a PHY responder.
module mdio_c45_master_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    logic        phy_oe = 1'b0;
    logic        phy_val = 1'b1;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // wire resolution with pull-up
    assign mdio_in = mdio_oe ? mdio_out : (phy_oe ? phy_val : 1'b1);

    mdio_c45_master u_mdio_c45_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    // model state
    int          m_phase = 0;   // 0 idle, 1 launch cycle, 2 on the wire
    int          m_t = 0;
    int          m_lim = 1;
    int          m_kind = 0;    // 0 address, 1 write, 3 read
    logic [63:0] m_frame = '1;
    logic [7:0]  m_div = 8'd100;
    logic [4:0]  m_prt = '0;
    logic [4:0]  m_dev = '0;
    logic [15:0] m_regnum = '0;
    logic [15:0] m_data = '0;
    bit          m_err = 0;
    bit          m_dbusy = 0;
    bit          phy_present = 0;
    logic [15:0] phy_value = '0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg(input logic [1:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            2'd0: begin v[0] = (m_phase != 0); v[1] = m_err; v[15:8] = m_div; end
            2'd1: begin v[4:0] = m_prt; v[12:8] = m_dev; end
            2'd2: v[15:0] = m_regnum;
            default: begin v[15:0] = m_data; v[31] = m_dbusy; end
        endcase
        return v;
    endfunction

    task automatic launch(input int k);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] pay;
        op  = 2'(k);
        ta  = (k == 3) ? 2'b11 : 2'b10;
        pay = (k == 0) ? m_regnum : ((k == 1) ? m_data : 16'hFFFF);
        m_kind  = k;
        m_phase = 1;
        m_lim   = (m_div == 0) ? 1 : int'(m_div);
        m_frame = {32'hFFFF_FFFF, 2'b00, op, m_prt, m_dev, ta, pay};
        if (k != 0) begin
            m_dbusy = 1;
            m_err   = 0;
        end
    endtask

    // model step, away from the active edge
    always @(posedge clk) begin
        #3;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_div = 8'd100; m_prt = '0; m_dev = '0;
            m_regnum = '0; m_data = '0; m_err = 0; m_dbusy = 0;
            phy_oe = 1'b0;
        end else begin
            bit busy_before;
            busy_before = (m_phase != 0);
            if (m_phase == 2) begin
                m_t++;
                if (m_t == 128 * m_lim) begin
                    m_phase = 0;
                    if (m_kind == 3) begin
                        m_err  = !phy_present;
                        m_data = phy_present ? phy_value : 16'hFFFF;
                    end
                    if (m_kind != 0) m_dbusy = 0;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
                m_t = 0;
            end
            if (reg_wr && !busy_before) begin
                case (reg_addr)
                    2'd0: m_div = reg_wdata[15:8];
                    2'd1: begin
                        m_prt = reg_wdata[4:0];
                        m_dev = reg_wdata[12:8];
                        if (reg_wdata[15]) launch(3);
                    end
                    2'd2: begin m_regnum = reg_wdata[15:0]; launch(0); end
                    default: begin m_data = reg_wdata[15:0]; launch(1); end
                endcase
            end
            // expected pins and PHY drive
            if (m_phase == 2) begin
                int  b;
                bit  hi;
                bit  eoe;
                b   = m_t / (2 * m_lim);
                hi  = (m_t % (2 * m_lim)) >= m_lim;
                eoe = !(m_kind == 3 && b >= 46);
                chk(mdc == hi, "R2 mdc", 32'(mdc), 32'(hi));
                chk(mdio_oe == eoe, "R5 oe", 32'(mdio_oe), 32'(eoe));
                if (eoe)
                    chk(mdio_out == m_frame[63 - b], "R3 R4 R9 bit",
                        32'(mdio_out), 32'(m_frame[63 - b]));
                if (m_kind == 3 && phy_present && b >= 47) begin
                    phy_oe  = 1'b1;
                    phy_val = (b == 47) ? 1'b0 : phy_value[15 - (b - 48)];
                end else begin
                    phy_oe = 1'b0;
                end
            end else begin
                phy_oe = 1'b0;
                chk(!mdc && !mdio_oe, "R2 idle", {30'd0, mdc, mdio_oe}, 32'd0);
            end
            chk(reg_rdata == exp_reg(reg_addr), "R6 R7 R8 regs",
                reg_rdata, exp_reg(reg_addr));
        end
        if (cyc > 150000 && !finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic read_check(input logic [1:0] a, input logic [31:0] exp,
                              input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_phase != 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_check(2'd0, 32'h0000_6400, "R1 status");
        read_check(2'd3, 32'h0000_0000, "R1 data");
        chk(!mdc && !mdio_oe, "R1 pins", {30'd0, mdc, mdio_oe}, 32'd0);

        // R4 address frame, port 5 device 1, divider 2
        write_reg(2'd0, 32'h0000_0200);
        write_reg(2'd1, 32'h0000_0105);
        read_check(2'd1, 32'h0000_0105, "R4 ctrl");
        write_reg(2'd2, 32'h0000_A5C3);
        read_check(2'd0, 32'h0000_0201, "R7 bus busy");
        // R8 writes during a frame are dropped
        write_reg(2'd2, 32'h0000_1111);
        write_reg(2'd0, 32'h0000_0700);
        write_reg(2'd1, 32'h0000_8000);
        wait_idle();
        read_check(2'd2, 32'h0000_A5C3, "R8 addr kept");
        read_check(2'd0, 32'h0000_0200, "R8 divider kept");
        read_check(2'd1, 32'h0000_0105, "R8 ctrl kept");

        // R4 write frame
        write_reg(2'd3, 32'h0000_1234);
        read_check(2'd3, 32'h8000_1234, "R7 data busy");
        wait_idle();
        read_check(2'd3, 32'h0000_1234, "R4 data");

        // R5 read with responding PHY
        phy_present = 1; phy_value = 16'hBEEF;
        write_reg(2'd1, 32'h0000_8105);
        wait_idle();
        read_check(2'd3, 32'h0000_BEEF, "R5 read data");
        read_check(2'd0, 32'h0000_0200, "R6 no error");
        read_check(2'd1, 32'h0000_0105, "R5 read bit clear");

        // R6 read with no PHY
        phy_present = 0;
        write_reg(2'd1, 32'h0000_8105);
        wait_idle();
        read_check(2'd0, 32'h0000_0202, "R6 error set");
        read_check(2'd3, 32'h0000_FFFF, "R6 all ones");
        write_reg(2'd2, 32'h0000_0042);
        wait_idle();
        read_check(2'd0, 32'h0000_0202, "R6 kept by address frame");
        write_reg(2'd3, 32'h0000_00C0);
        wait_idle();
        read_check(2'd0, 32'h0000_0200, "R6 cleared by write frame");

        // R2 zero divider acts as one, new port and device
        write_reg(2'd0, 32'h0000_0000);
        write_reg(2'd1, 32'h0000_1F1E);
        read_check(2'd1, 32'h0000_1F1E, "R3 ctrl fields");
        write_reg(2'd2, 32'h0000_5A5A);
        wait_idle();

        // R5 read at divider 3
        write_reg(2'd0, 32'h0000_0300);
        phy_present = 1; phy_value = 16'h0001;
        write_reg(2'd1, 32'h0000_8001);
        wait_idle();
        read_check(2'd3, 32'h0000_0001, "R5 read data 2");

        // R2 divider 100
        write_reg(2'd0, 32'h0000_6400);
        write_reg(2'd2, 32'h0000_C0DE);
        wait_idle();
        read_check(2'd2, 32'h0000_C0DE, "R4 addr");

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule